// File: doc/BRIEF.md
# Spare Cell Allocation Controller

This block manages the repair of a grid of identical working positions. Working cells and spare cells are laid out as a checkerboard on a torus of `ROWS` rows by `2*COLS` columns. Every working position therefore touches four spares, and every spare touches four working positions. When the fault flag of a position rises, the controller isolates the cell that is active there and hands its job to a free neighbouring spare. It records the hand-over in the index bits of that spare.

Each spare carries three index fields. The state bit is set once the spare has been used. The two-bit direction field points from the spare toward the position it serves. The differentiation bit is set while the spare is doing that position's work. A replacement spare becomes the active cell of its position, so a later rising fault at the same position retires it and triggers another repair. Faults at several positions in one cycle are settled in that same cycle by a chained arbiter.

Per-spare state machine: `SP_FREE` goes to `SP_ACTIVE` on *allocate*, and `SP_ACTIVE` goes to `SP_RETIRED` on *retire*. Per-position state machine: `POS_HEALTHY` goes to `POS_REPAIRED` on *grant*. `POS_REPAIRED` stays in `POS_REPAIRED` on *grant*. `POS_HEALTHY` or `POS_REPAIRED` goes to `POS_DEAD` on *fail*. Controller state machine: `CTRL_OK` goes to `CTRL_DEGRADED` when any position fails.

Top module: `spare_alloc_ctrl`

## Requirements
- R1: After reset, all spare state, direction and differentiation bits are 0, all isolate flags are 0 and the unrecoverable flag is 0.
- R2: Working position k sits at row r=k/COLS, column x=2*(k%COLS)+(r%2). Its left, down, right and top spares are the cells at (r,x-1), (r+1,x), (r,x+1) and (r-1,x), with wrap-around. The spare at (r,x) has index r*COLS+x/2.
- R3: A faulting position takes the first free neighbour in the order left, down, right, top. A neighbour that is active or retired is skipped.
- R4: The direction code of a spare names the position it serves, seen from the spare: 00 left, 01 down, 10 right, 11 top. The code is held once the spare has been used. spare_dir_o[2s+1:2s] belongs to spare s.
- R5: The state bit of a spare (spare_state_o[s]) goes to 1 when the spare is allocated and never returns to 0 until reset.
- R6: The differentiation bit (spare_diff_o[s]) is 1 while the spare is the active cell of its position. It clears when that position's fault rises again.
- R7: isolate_o[k] is set by the first fault at position k and stays set.
- R8: Only a 0-to-1 change of fault_i[k] is a fault. Holding the flag high causes no further repair.
- R9: Faults at several positions in the same cycle are all handled in that cycle, and no spare goes to two positions. When two positions contend for a spare, the lower index wins and the other moves on to its next candidate in the same cycle.
- R10: A fault with no free neighbour moves the position to a dead state and sets unrecoverable_o, which stays set. A dead position ignores later faults.
- R11: All outputs reflect a rising fault right after the first clock edge that samples fault_i high.
- R12: One position can be repaired up to four times, once by each neighbouring spare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_i | input | ROWS*COLS | Fault flag per working position |
| spare_state_o | output | ROWS*COLS | Used bit per spare |
| spare_dir_o | output | 2*ROWS*COLS | Direction code per spare |
| spare_diff_o | output | ROWS*COLS | Active-replacement bit per spare |
| isolate_o | output | ROWS*COLS | Original cell at the position is isolated |
| unrecoverable_o | output | 1 | Some position ran out of free spares |

## Verification
The hardest case to reach from the ports is a same-cycle contest in which the later choice of a lower-indexed position lands on the first choice of a higher-indexed position. At reset no two positions share a first choice, so history must first make some first choices busy. The stimulus faults one position repeatedly to use up its left spare. It then raises that position again together with a neighbour whose left spare is the first position's down spare. A final burst that raises every flag at once exhausts the grid and drives several positions into the dead state in a single cycle.

// File: rtl/spare_repair_pkg.sv
`timescale 1ns/1ps
package spare_repair_pkg;

    typedef enum logic [1:0] {
        SP_FREE    = 2'd0,
        SP_ACTIVE  = 2'd1,
        SP_RETIRED = 2'd2
    } spare_state_e;

    typedef enum logic [1:0] {
        POS_HEALTHY  = 2'd0,
        POS_REPAIRED = 2'd1,
        POS_DEAD     = 2'd2
    } pos_state_e;

    typedef enum logic {
        CTRL_OK       = 1'b0,
        CTRL_DEGRADED = 1'b1
    } ctrl_state_e;

    // neighbour order / direction encoding: 0 left, 1 down, 2 right, 3 top
    function automatic int wrap_idx(input int v, input int m);
        return ((v % m) + m) % m;
    endfunction

    function automatic int step_to(input int r, input int x, input int d,
                                   input int rows, input int cols);
        int nr;
        int nx;
        nr = r;
        nx = x;
        case (d)
            0:       nx = x - 1;
            1:       nr = r + 1;
            2:       nx = x + 1;
            default: nr = r - 1;
        endcase
        nr = wrap_idx(nr, rows);
        nx = wrap_idx(nx, 2 * cols);
        return nr * cols + nx / 2;
    endfunction

    function automatic int spare_of_cell(input int k, input int d,
                                         input int rows, input int cols);
        int r;
        r = k / cols;
        return step_to(r, 2 * (k % cols) + (r % 2), d, rows, cols);
    endfunction

    function automatic int cell_of_spare(input int s, input int d,
                                         input int rows, input int cols);
        int r;
        r = s / cols;
        return step_to(r, 2 * (s % cols) + 1 - (r % 2), d, rows, cols);
    endfunction

endpackage

// File: rtl/spare_arbiter.sv
`timescale 1ns/1ps
module spare_arbiter #(
    parameter int ROWS = 4,
    parameter int COLS = 2,
    localparam int NCELL = ROWS * COLS,
    localparam int IDXW = $clog2(NCELL)
) (
    input  logic [NCELL-1:0]      req_i,
    input  logic [NCELL-1:0]      free_i,
    output logic [NCELL-1:0]      grant_o,
    output logic [NCELL-1:0]      fail_o,
    output logic [2*NCELL-1:0]    gdir_o,
    output logic [IDXW*NCELL-1:0] gspare_o
);
    import spare_repair_pkg::*;

    logic [IDXW-1:0] nbr [NCELL][4];

    for (genvar gk = 0; gk < NCELL; gk++) begin : g_cell
        for (genvar gd = 0; gd < 4; gd++) begin : g_dir
            assign nbr[gk][gd] = IDXW'(spare_of_cell(gk, gd, ROWS, COLS));
        end
    end

    // lower index claims first; each claim removes the spare for later cells
    always_comb begin
        logic [NCELL-1:0] avail;
        logic             found;
        avail    = free_i;
        grant_o  = '0;
        fail_o   = '0;
        gdir_o   = '0;
        gspare_o = '0;
        for (int k = 0; k < NCELL; k++) begin
            found = 1'b0;
            if (req_i[k]) begin
                for (int d = 0; d < 4; d++) begin
                    if (!found && avail[nbr[k][d]]) begin
                        found                        = 1'b1;
                        avail[nbr[k][d]]             = 1'b0;
                        gdir_o[2*k +: 2]             = 2'(d);
                        gspare_o[IDXW*k +: IDXW]     = nbr[k][d];
                    end
                end
                grant_o[k] = found;
                fail_o[k]  = !found;
            end
        end
    end

endmodule

// File: rtl/spare_cell_ctrl.sv
`timescale 1ns/1ps
module spare_cell_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       alloc_i,
    input  logic [1:0] code_i,
    input  logic       retire_i,
    output logic       state_bit_o,
    output logic       diff_o,
    output logic [1:0] dir_o
);
    import spare_repair_pkg::*;

    spare_state_e st_q, st_d;
    logic [1:0]   dir_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SP_FREE:    if (alloc_i)  st_d = SP_ACTIVE;
            SP_ACTIVE:  if (retire_i) st_d = SP_RETIRED;
            SP_RETIRED: st_d = SP_RETIRED;
            default:    st_d = SP_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SP_FREE;
            dir_q <= 2'b00;
        end else begin
            st_q <= st_d;
            if (st_q == SP_FREE && alloc_i) dir_q <= code_i;
        end
    end

    always_comb begin
        state_bit_o = (st_q != SP_FREE);
        diff_o      = (st_q == SP_ACTIVE);
        dir_o       = dir_q;
    end

    p_alloc_free_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> (st_q == SP_FREE));
    p_state_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state_bit_o |=> state_bit_o);
    p_diff_from_alloc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(diff_o) |-> $past(alloc_i));
    p_dir_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state_bit_o |=> $stable(dir_o));

endmodule

// File: rtl/repair_position.sv
`timescale 1ns/1ps
module repair_position (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_i,
    input  logic grant_i,
    input  logic fail_i,
    output logic req_o,
    output logic isolate_o,
    output logic dead_o
);
    import spare_repair_pkg::*;

    pos_state_e st_q, st_d;
    logic       fault_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            POS_HEALTHY:  if (fail_i) st_d = POS_DEAD;
                          else if (grant_i) st_d = POS_REPAIRED;
            POS_REPAIRED: if (fail_i) st_d = POS_DEAD;
            POS_DEAD:     st_d = POS_DEAD;
            default:      st_d = POS_HEALTHY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= POS_HEALTHY;
            fault_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            fault_q <= fault_i;
        end
    end

    always_comb begin
        req_o     = fault_i && !fault_q && (st_q != POS_DEAD);
        isolate_o = (st_q != POS_HEALTHY);
        dead_o    = (st_q == POS_DEAD);
    end

    p_answer_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_i || fail_i) |-> req_o);
    p_grant_fail_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_i && fail_i));
    p_isolate_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        isolate_o |=> isolate_o);
    p_isolate_next_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> isolate_o);
    p_dead_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dead_o |=> dead_o);

endmodule

// File: rtl/spare_alloc_ctrl.sv
`timescale 1ns/1ps
module spare_alloc_ctrl #(
    parameter int ROWS = 4,
    parameter int COLS = 2,
    localparam int NCELL = ROWS * COLS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCELL-1:0]     fault_i,
    output logic [NCELL-1:0]     spare_state_o,
    output logic [2*NCELL-1:0]   spare_dir_o,
    output logic [NCELL-1:0]     spare_diff_o,
    output logic [NCELL-1:0]     isolate_o,
    output logic                 unrecoverable_o
);
    import spare_repair_pkg::*;

    localparam int IDXW = $clog2(NCELL);

    logic [NCELL-1:0]      req, grant, fail, dead, alloc, retire;
    logic [2*NCELL-1:0]    gdir;
    logic [IDXW*NCELL-1:0] gspare;
    ctrl_state_e           ctrl_q, ctrl_d;

    for (genvar gk = 0; gk < NCELL; gk++) begin : g_pos
        repair_position u_pos (
            .clk       (clk),
            .rst_n     (rst_n),
            .fault_i   (fault_i[gk]),
            .grant_i   (grant[gk]),
            .fail_i    (fail[gk]),
            .req_o     (req[gk]),
            .isolate_o (isolate_o[gk]),
            .dead_o    (dead[gk])
        );

        p_fail_kills_r10: assert property (@(posedge clk) disable iff (!rst_n)
            fail[gk] |=> (dead[gk] && unrecoverable_o));
    end

    spare_arbiter #(.ROWS(ROWS), .COLS(COLS)) u_arb (
        .req_i    (req),
        .free_i   (~spare_state_o),
        .grant_o  (grant),
        .fail_o   (fail),
        .gdir_o   (gdir),
        .gspare_o (gspare)
    );

    for (genvar gs = 0; gs < NCELL; gs++) begin : g_spare
        logic [NCELL-1:0] claim_g;
        logic [1:0]       code_g;
        logic [IDXW-1:0]  srv_g [4];

        for (genvar gk = 0; gk < NCELL; gk++) begin : g_claim
            assign claim_g[gk] = grant[gk] &&
                                 (gspare[IDXW*gk +: IDXW] == IDXW'(gs));
        end

        for (genvar gd = 0; gd < 4; gd++) begin : g_srv
            assign srv_g[gd] = IDXW'(cell_of_spare(gs, gd, ROWS, COLS));
        end

        // code from the spare toward the cell: opposite of the cell's view
        always_comb begin
            code_g = 2'b00;
            for (int k = 0; k < NCELL; k++) begin
                if (claim_g[k]) code_g = gdir[2*k +: 2] + 2'd2;
            end
        end

        assign alloc[gs]  = |claim_g;
        assign retire[gs] = spare_diff_o[gs] && req[srv_g[spare_dir_o[2*gs +: 2]]];

        spare_cell_ctrl u_spare (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc_i     (alloc[gs]),
            .code_i      (code_g),
            .retire_i    (retire[gs]),
            .state_bit_o (spare_state_o[gs]),
            .diff_o      (spare_diff_o[gs]),
            .dir_o       (spare_dir_o[2*gs +: 2])
        );

        p_single_claim_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(claim_g) <= 1);
        p_claim_was_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
            alloc[gs] |-> !spare_state_o[gs]);
    end

    always_comb begin
        ctrl_d = ctrl_q;
        unique case (ctrl_q)
            CTRL_OK:       if (|fail) ctrl_d = CTRL_DEGRADED;
            CTRL_DEGRADED: ctrl_d = CTRL_DEGRADED;
            default:       ctrl_d = CTRL_OK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= CTRL_OK;
        else        ctrl_q <= ctrl_d;
    end

    always_comb unrecoverable_o = (ctrl_q == CTRL_DEGRADED);

    p_unrec_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        unrecoverable_o |=> unrecoverable_o);

endmodule

// File: tb/spare_alloc_ctrl_test.sv
`timescale 1ns/1ps
module spare_alloc_ctrl_test;

    localparam int NC   = 8;
    localparam int WDOG = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] fault = '0;
    logic [NC-1:0] st, df, iso;
    logic [2*NC-1:0] dir;
    logic          unrec;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    spare_alloc_ctrl uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .fault_i         (fault),
        .spare_state_o   (st),
        .spare_dir_o     (dir),
        .spare_diff_o    (df),
        .isolate_o       (iso),
        .unrecoverable_o (unrec)
    );

    // {fault, state, diff, isolate, dir, unrec}
    localparam logic [48:0] STEPS [15] = '{
        {8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 1'b0}, // R1 idle after reset
        {8'h01, 8'h02, 8'h02, 8'h01, 16'h0008, 1'b0}, // R3 R4 cell0 -> left spare1, code 10
        {8'h00, 8'h02, 8'h02, 8'h01, 16'h0008, 1'b0},
        {8'h05, 8'h16, 8'h14, 8'h05, 16'h0338, 1'b0}, // R9 cell0 wins spare2, cell2 -> spare4
        {8'h00, 8'h16, 8'h14, 8'h05, 16'h0338, 1'b0},
        {8'h01, 8'h17, 8'h11, 8'h05, 16'h0338, 1'b0}, // R6 cell0 third repair, right spare0
        {8'h00, 8'h17, 8'h11, 8'h05, 16'h0338, 1'b0},
        {8'h01, 8'h57, 8'h50, 8'h05, 16'h1338, 1'b0}, // R12 fourth repair, top spare6 code 01
        {8'h00, 8'h57, 8'h50, 8'h05, 16'h1338, 1'b0},
        {8'h01, 8'h57, 8'h10, 8'h05, 16'h1338, 1'b1}, // R10 cell0 exhausted
        {8'h00, 8'h57, 8'h10, 8'h05, 16'h1338, 1'b1},
        {8'h01, 8'h57, 8'h10, 8'h05, 16'h1338, 1'b1}, // R10 dead cell ignores fault
        {8'hFF, 8'hFF, 8'hA8, 8'hFF, 16'hDFF8, 1'b1}, // R9 all at once
        {8'h00, 8'hFF, 8'hA8, 8'hFF, 16'hDFF8, 1'b1},
        {8'hFF, 8'hFF, 8'h00, 8'hFF, 16'hDFF8, 1'b1}  // R6 R10 every spare retired
    };

    function automatic string step_tag(input int i);
        case (i)
            0:       return "R1";
            1:       return "R2 R3 R4 R5 R7 R11";
            3:       return "R9 R3 R6";
            5, 7:    return "R12 R3 R6";
            9:       return "R10";
            11:      return "R10 R8";
            12:      return "R9 R2";
            14:      return "R6 R10";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic apply(input logic [48:0] v, input string tag);
        @(negedge clk);
        fault = v[48:41];
        @(negedge clk);
        check(tag, "state bits", 16'(st),    16'(v[40:33]));
        check(tag, "diff bits",  16'(df),    16'(v[32:25]));
        check(tag, "isolate",    16'(iso),   16'(v[24:17]));
        check(tag, "direction",  dir,        v[16:1]);
        check(tag, "unrecov",    16'(unrec), 16'(v[0]));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == WDOG) begin
            errors++;
            $display("FAIL R11 watchdog: got %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 15; i++) apply(STEPS[i], step_tag(i));

        // R1: reset in the middle of a run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        fault = '0;
        @(negedge clk);
        check("R1", "state after reset", 16'(st), 16'h0000);
        check("R1", "diff after reset", 16'(df), 16'h0000);
        check("R1", "isolate after reset", 16'(iso), 16'h0000);
        check("R1", "dir after reset", dir, 16'h0000);
        check("R1", "unrecov after reset", 16'(unrec), 16'h0000);
        rst_n = 1'b1;

        // R8: cell3 held high repairs once (left spare3, code 10)
        apply({8'h08, 8'h08, 8'h08, 8'h08, 16'h0080, 1'b0}, "R8 R11");
        repeat (4) @(negedge clk);
        check("R8", "state held", 16'(st), 16'h0008);
        check("R8", "diff held", 16'(df), 16'h0008);
        check("R8", "dir held", dir, 16'h0080);

        // R3: cell5 walks left s4, down s7, right s5, top s3 busy -> fail
        apply({8'h28, 8'h18, 8'h18, 8'h28, 16'h0280, 1'b0}, "R3 R4");
        apply({8'h08, 8'h18, 8'h18, 8'h28, 16'h0280, 1'b0}, "R8");
        apply({8'h28, 8'h98, 8'h88, 8'h28, 16'hC280, 1'b0}, "R3 R6");
        apply({8'h08, 8'h98, 8'h88, 8'h28, 16'hC280, 1'b0}, "R8");
        apply({8'h28, 8'hB8, 8'h28, 8'h28, 16'hC280, 1'b0}, "R3 R4");
        apply({8'h08, 8'hB8, 8'h28, 8'h28, 16'hC280, 1'b0}, "R8");
        apply({8'h28, 8'hB8, 8'h08, 8'h28, 16'hC280, 1'b1}, "R3 R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule